// File: doc/BRIEF.md
# Integer Multiply/Divide Engine with HI/LO Interlock

This block is the multicycle integer multiply and divide engine that sits beside a processor's main ALU. It accepts 32-bit and 64-bit signed and unsigned multiplies and divides. It also accepts 32-bit multiply-accumulate and multiply-subtract operations that fold a product into the HI/LO pair. Results land in two 64-bit result registers, HI and LO. Each operation class has its own fixed latency, and its own repeat interval before another operation may be accepted.

The issue logic presents a request with `req_valid_i`. While the repeat interval of the operation in flight has not run out, the engine answers with `req_stall_o`, and the request must stay on the port until it is taken. A read of HI or LO is signalled on `rd_req_i`. The engine answers with `rd_stall_o` for as long as a result is still pending. A mode pin, sampled only while reset is held, stretches every multiply-type operation by one cycle of latency and one cycle of repeat.

Control is a two-state machine. IDLE moves to BUSY on LAUNCH, when an operation is accepted. BUSY stays in BUSY on HOLD, while the latency count has not expired. It also stays in BUSY on CHAIN, when a new operation is accepted in the same cycle the current one completes. BUSY returns to IDLE on RETIRE, when the operation completes and nothing new is accepted. Operands are captured when an operation is accepted, and the result is evaluated when it completes. An accumulation therefore always sees the HI/LO value left by the operation before it.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read zero, `busy_o` is low, and neither stall output is asserted while no request is present.
- R2: Opcodes 0 (signed) and 1 (unsigned) multiply the low 32 bits of the operands. LO receives product bits 31:0 and HI receives product bits 63:32, each sign-extended from its bit 31 to 64 bits.
- R3: Opcodes 2 (signed) and 3 (unsigned) multiply the full 64-bit operands. HI receives bits 127:64 of the 128-bit product and LO receives bits 63:0.
- R4: Opcodes 4/5 (32-bit signed/unsigned) and 6/7 (64-bit signed/unsigned) divide A by B. LO receives the quotient, truncated toward zero, and HI receives the remainder, which takes the sign of the dividend. The 32-bit forms work on the low words and sign-extend both results from bit 31. The most negative dividend divided by minus one gives a quotient equal to that dividend and a remainder of zero.
- R5: A divide by a zero divisor completes at the normal divide latency and raises nothing. LO is all ones, and HI is the dividend: the sign-extended low word for the 32-bit forms, or the full operand for the 64-bit forms.
- R6: Opcodes 8/9 (signed/unsigned) add, and opcodes 10/11 (signed/unsigned) subtract, the 64-bit product of the low words to or from {HI[31:0], LO[31:0]}. The sum is split and sign-extended like an R2 result.
- R7: With the stretch mode off, the latency L is 4 for opcodes 0/1, 6 for 2/3, 36 for 4/5, 68 for 6/7, 3 for 8/9 and 4 for 10/11. Counting the accepting cycle as cycle 0, `busy_o` is high in cycles 1 to L-1, and the new HI/LO values are visible from cycle L.
- R8: With the stretch mode off, the repeat interval R is 3 for opcodes 0/1, 5 for 2/3, 36 for 4/5, 68 for 6/7, 2 for 8/9 and 3 for 10/11. A request held from cycle 1 sees `req_stall_o` in cycles 1 to R-1 and is accepted in cycle R. An accumulation accepted back-to-back uses the result of the operation before it.
- R9: `rd_stall_o` is high exactly in those cycles where `rd_req_i` is high and an accepted operation has not yet made its result visible.
- R10: A high `slow_mul_i` during reset adds one cycle to both L and R of opcodes 0-3 and 8-11 and leaves divides unchanged. The pin is ignored once reset is released.
- R11: Opcodes 12 to 15 are reserved. A request carrying one of them is never stalled, does not make the engine busy, and leaves HI and LO unchanged.
- R12: HI and LO change only at the clock edge that completes an operation. While the engine is not busy, they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the stretch mode is sampled while it is low |
| slow_mul_i | input | 1 | Multiply stretch mode, captured during reset |
| req_valid_i | input | 1 | An operation is presented |
| req_op_i | input | 4 | Opcode, per R2-R6 and R11 |
| req_a_i | input | 64 | First operand (dividend or multiplicand) |
| req_b_i | input | 64 | Second operand (divisor or multiplier) |
| req_stall_o | output | 1 | The presented operation cannot be taken this cycle |
| rd_req_i | input | 1 | The issue logic wants to read HI or LO |
| rd_stall_o | output | 1 | The read must wait for the pending result |
| busy_o | output | 1 | An accepted operation has not yet written its result |
| hi_o | output | 64 | HI result register |
| lo_o | output | 64 | LO result register |

## Verification
The hardest situation to reach from the ports is the CHAIN transition. Here a new operation is accepted on the very edge where the previous one writes HI/LO, and that new operation accumulates on top of the value just written. The bench reaches it by presenting a multiply-accumulate in the cycle right after each opcode is accepted and holding it through the stall. It counts the stall cycles and then compares HI/LO against two chained model steps. The stretched timing can only be reached through a second reset with the mode pin high. After that reset the bench flips the pin and sweeps every opcode again, to show that the captured mode, and not the live pin, sets the cycle counts.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int unsigned DW = 64;
    localparam int unsigned HW = DW / 2;

    typedef enum logic [3:0] {
        OP_MUL_W   = 4'd0,
        OP_MULU_W  = 4'd1,
        OP_MUL_D   = 4'd2,
        OP_MULU_D  = 4'd3,
        OP_DIV_W   = 4'd4,
        OP_DIVU_W  = 4'd5,
        OP_DIV_D   = 4'd6,
        OP_DIVU_D  = 4'd7,
        OP_MACC    = 4'd8,
        OP_MACCU   = 4'd9,
        OP_MSUB    = 4'd10,
        OP_MSUBU   = 4'd11
    } md_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } md_state_e;

    function automatic int unsigned md_max(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

    function automatic logic [DW-1:0] sext_half(input logic [HW-1:0] v);
        return {{HW{v[HW-1]}}, v};
    endfunction

endpackage

// File: rtl/muldiv_divcore.sv
module muldiv_divcore #(
    parameter int unsigned W = 32
) (
    input  logic         sgn_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    logic         neg_n;
    logic         neg_d;
    logic [W-1:0] mag_n;
    logic [W-1:0] mag_d;
    logic [W-1:0] q_m;
    logic [W-1:0] r_m;

    always_comb begin
        neg_n = sgn_i & num_i[W-1];
        neg_d = sgn_i & den_i[W-1];
        mag_n = neg_n ? -num_i : num_i;
        mag_d = neg_d ? -den_i : den_i;
        q_m   = '0;
        r_m   = '0;
        if (den_i == '0) begin
            quo_o = '1;
            rem_o = num_i;
        end else begin
            q_m   = mag_n / mag_d;
            r_m   = mag_n % mag_d;
            quo_o = (neg_n ^ neg_d) ? -q_m : q_m;
            rem_o = neg_n ? -r_m : r_m;
        end
    end

endmodule

// File: rtl/muldiv_arith.sv
module muldiv_arith
    import muldiv_pkg::*;
(
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] acc_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);

    logic              sgn;
    logic [DW-1:0]     ea_w;
    logic [DW-1:0]     eb_w;
    logic [DW-1:0]     prod_w;
    logic [2*DW-1:0]   ea_d;
    logic [2*DW-1:0]   eb_d;
    logic [2*DW-1:0]   prod_d;
    logic [DW-1:0]     sum_w;
    logic [1:0][DW-1:0] quo;
    logic [1:0][DW-1:0] rem;

    assign sgn    = ~op_i[0];
    assign ea_w   = sgn ? sext_half(a_i[HW-1:0]) : {{HW{1'b0}}, a_i[HW-1:0]};
    assign eb_w   = sgn ? sext_half(b_i[HW-1:0]) : {{HW{1'b0}}, b_i[HW-1:0]};
    assign prod_w = ea_w * eb_w;
    assign ea_d   = sgn ? {{DW{a_i[DW-1]}}, a_i} : {{DW{1'b0}}, a_i};
    assign eb_d   = sgn ? {{DW{b_i[DW-1]}}, b_i} : {{DW{1'b0}}, b_i};
    assign prod_d = ea_d * eb_d;
    assign sum_w  = op_i[1] ? (acc_i - prod_w) : (acc_i + prod_w);

    for (genvar g = 0; g < 2; g++) begin : g_div
        localparam int unsigned W = (g == 0) ? HW : DW;
        logic [W-1:0] q;
        logic [W-1:0] r;
        muldiv_divcore #(.W(W)) u_div (
            .sgn_i (sgn),
            .num_i (a_i[W-1:0]),
            .den_i (b_i[W-1:0]),
            .quo_o (q),
            .rem_o (r)
        );
        if (W < DW) begin : g_narrow
            assign quo[g] = {{HW{q[W-1]}}, q};
            assign rem[g] = {{HW{r[W-1]}}, r};
        end else begin : g_full
            assign quo[g] = q;
            assign rem[g] = r;
        end
    end

    always_comb begin
        hi_o = '0;
        lo_o = '0;
        unique case (op_i)
            OP_MUL_W, OP_MULU_W: begin
                hi_o = sext_half(prod_w[DW-1:HW]);
                lo_o = sext_half(prod_w[HW-1:0]);
            end
            OP_MUL_D, OP_MULU_D: begin
                hi_o = prod_d[2*DW-1:DW];
                lo_o = prod_d[DW-1:0];
            end
            OP_DIV_W, OP_DIVU_W: begin
                hi_o = rem[0];
                lo_o = quo[0];
            end
            OP_DIV_D, OP_DIVU_D: begin
                hi_o = rem[1];
                lo_o = quo[1];
            end
            OP_MACC, OP_MACCU, OP_MSUB, OP_MSUBU: begin
                hi_o = sext_half(sum_w[DW-1:HW]);
                lo_o = sext_half(sum_w[HW-1:0]);
            end
            default: begin
                hi_o = '0;
                lo_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/muldiv_timing.sv
module muldiv_timing
    import muldiv_pkg::*;
#(
    parameter int unsigned CW         = 7,
    parameter int unsigned LAT_MUL_W  = 4,
    parameter int unsigned REP_MUL_W  = 3,
    parameter int unsigned LAT_MUL_D  = 6,
    parameter int unsigned REP_MUL_D  = 5,
    parameter int unsigned LAT_DIV_W  = 36,
    parameter int unsigned LAT_DIV_D  = 68,
    parameter int unsigned LAT_MACC   = 3,
    parameter int unsigned REP_MACC   = 2,
    parameter int unsigned LAT_MSUB   = 4,
    parameter int unsigned REP_MSUB   = 3,
    parameter int unsigned SLOW_EXTRA = 1
) (
    input  logic [3:0]    op_i,
    input  logic          slow_i,
    output logic          legal_o,
    output logic [CW-1:0] lat_o,
    output logic [CW-1:0] rep_o
);

    int unsigned base_l;
    int unsigned base_r;
    int unsigned extra;
    logic        mulish;

    always_comb begin
        base_l  = 0;
        base_r  = 0;
        mulish  = 1'b0;
        legal_o = 1'b1;
        unique case (op_i)
            OP_MUL_W, OP_MULU_W: begin base_l = LAT_MUL_W; base_r = REP_MUL_W; mulish = 1'b1; end
            OP_MUL_D, OP_MULU_D: begin base_l = LAT_MUL_D; base_r = REP_MUL_D; mulish = 1'b1; end
            OP_DIV_W, OP_DIVU_W: begin base_l = LAT_DIV_W; base_r = LAT_DIV_W; end
            OP_DIV_D, OP_DIVU_D: begin base_l = LAT_DIV_D; base_r = LAT_DIV_D; end
            OP_MACC, OP_MACCU:   begin base_l = LAT_MACC;  base_r = REP_MACC;  mulish = 1'b1; end
            OP_MSUB, OP_MSUBU:   begin base_l = LAT_MSUB;  base_r = REP_MSUB;  mulish = 1'b1; end
            default:             legal_o = 1'b0;
        endcase
        extra = (mulish && slow_i) ? SLOW_EXTRA : 0;
        lat_o = CW'(base_l + extra);
        rep_o = CW'(base_r + extra);
    end

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_ok_i,
    input  logic [CW-1:0] lat_i,
    input  logic [CW-1:0] rep_i,
    output logic          accept_o,
    output logic          req_stall_o,
    output logic          busy_o,
    output logic          done_o
);

    md_state_e     st_q;
    md_state_e     st_d;
    logic [CW-1:0] lat_q;
    logic [CW-1:0] rep_q;
    logic          gate_open;
    logic          accept;
    logic          done;

    always_comb begin
        gate_open = (rep_q == '0);
        accept    = req_ok_i && gate_open;
        done      = (st_q == ST_BUSY) && (lat_q == CW'(1));
        st_d      = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_BUSY;
            ST_BUSY: if (done && !accept) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            lat_q <= '0;
            rep_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                lat_q <= lat_i - CW'(1);
                rep_q <= rep_i - CW'(1);
            end else begin
                if (lat_q != '0) lat_q <= lat_q - CW'(1);
                if (rep_q != '0) rep_q <= rep_q - CW'(1);
            end
        end
    end

    always_comb begin
        busy_o      = (st_q == ST_BUSY);
        req_stall_o = req_ok_i && !gate_open;
        accept_o    = accept;
        done_o      = done;
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int unsigned LAT_MUL_W  = 4,
    parameter int unsigned REP_MUL_W  = 3,
    parameter int unsigned LAT_MUL_D  = 6,
    parameter int unsigned REP_MUL_D  = 5,
    parameter int unsigned LAT_DIV_W  = 36,
    parameter int unsigned LAT_DIV_D  = 68,
    parameter int unsigned LAT_MACC   = 3,
    parameter int unsigned REP_MACC   = 2,
    parameter int unsigned LAT_MSUB   = 4,
    parameter int unsigned REP_MSUB   = 3,
    parameter int unsigned SLOW_EXTRA = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_mul_i,
    input  logic          req_valid_i,
    input  logic [3:0]    req_op_i,
    input  logic [DW-1:0] req_a_i,
    input  logic [DW-1:0] req_b_i,
    output logic          req_stall_o,
    input  logic          rd_req_i,
    output logic          rd_stall_o,
    output logic          busy_o,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);

    localparam int unsigned MUL_TOP = md_max(md_max(LAT_MUL_W, LAT_MUL_D),
                                             md_max(LAT_MACC, LAT_MSUB)) + SLOW_EXTRA;
    localparam int unsigned LAT_TOP = md_max(md_max(LAT_DIV_W, LAT_DIV_D), MUL_TOP);
    localparam int unsigned CW      = $clog2(LAT_TOP + 1);

    logic          slow_q;
    logic          legal;
    logic [CW-1:0] lat;
    logic [CW-1:0] rep;
    logic          accept;
    logic          done;
    logic [3:0]    pend_op;
    logic [DW-1:0] pend_a;
    logic [DW-1:0] pend_b;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_n;
    logic [DW-1:0] lo_n;

    always_ff @(posedge clk) begin
        if (!rst_n) slow_q <= slow_mul_i;
    end

    muldiv_timing #(
        .CW(CW), .LAT_MUL_W(LAT_MUL_W), .REP_MUL_W(REP_MUL_W),
        .LAT_MUL_D(LAT_MUL_D), .REP_MUL_D(REP_MUL_D),
        .LAT_DIV_W(LAT_DIV_W), .LAT_DIV_D(LAT_DIV_D),
        .LAT_MACC(LAT_MACC), .REP_MACC(REP_MACC),
        .LAT_MSUB(LAT_MSUB), .REP_MSUB(REP_MSUB),
        .SLOW_EXTRA(SLOW_EXTRA)
    ) u_timing (
        .op_i    (req_op_i),
        .slow_i  (slow_q),
        .legal_o (legal),
        .lat_o   (lat),
        .rep_o   (rep)
    );

    muldiv_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ok_i    (req_valid_i && legal),
        .lat_i       (lat),
        .rep_i       (rep),
        .accept_o    (accept),
        .req_stall_o (req_stall_o),
        .busy_o      (busy_o),
        .done_o      (done)
    );

    muldiv_arith u_arith (
        .op_i  (pend_op),
        .a_i   (pend_a),
        .b_i   (pend_b),
        .acc_i ({hi_q[HW-1:0], lo_q[HW-1:0]}),
        .hi_o  (hi_n),
        .lo_o  (lo_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_op <= '0;
            pend_a  <= '0;
            pend_b  <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            if (done) begin
                hi_q <= hi_n;
                lo_q <= lo_n;
            end
            if (accept) begin
                pend_op <= req_op_i;
                pend_a  <= req_a_i;
                pend_b  <= req_b_i;
            end
        end
    end

    assign rd_stall_o = rd_req_i && busy_o;
    assign hi_o       = hi_q;
    assign lo_o       = lo_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic [3:0]  req_op_i,
    input logic        req_stall_o,
    input logic        busy_o,
    input logic [63:0] hi_o,
    input logic [63:0] lo_o
);

    AST_HILO_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(hi_o) && $stable(lo_o))); // R12

    AST_ISSUE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_op_i <= 4'd11) && !req_stall_o) |=> busy_o); // R7

    AST_STALL_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall_o |-> busy_o); // R8

    AST_RESERVED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_op_i > 4'd11) && !busy_o) |=> !busy_o); // R11

endmodule

bind muldiv_unit muldiv_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_stall_o (req_stall_o),
    .busy_o      (busy_o),
    .hi_o        (hi_o),
    .lo_o        (lo_o)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_mul_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [3:0]  req_op_i = '0;
    logic [63:0] req_a_i = '0;
    logic [63:0] req_b_i = '0;
    logic        req_stall_o;
    logic        rd_req_i = 1'b0;
    logic        rd_stall_o;
    logic        busy_o;
    logic [63:0] hi_o;
    logic [63:0] lo_o;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [63:0] m_hi;
    logic [63:0] m_lo;
    logic [63:0] vals [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .slow_mul_i(slow_mul_i),
        .req_valid_i(req_valid_i), .req_op_i(req_op_i),
        .req_a_i(req_a_i), .req_b_i(req_b_i), .req_stall_o(req_stall_o),
        .rd_req_i(rd_req_i), .rd_stall_o(rd_stall_o), .busy_o(busy_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [3:0] op, input bit slow);
        int l;
        case (op)
            4'd0, 4'd1: l = 4;
            4'd2, 4'd3: l = 6;
            4'd4, 4'd5: l = 36;
            4'd6, 4'd7: l = 68;
            4'd8, 4'd9: l = 3;
            default:    l = 4;
        endcase
        if (slow && !(op inside {4'd4, 4'd5, 4'd6, 4'd7})) l++;
        return l;
    endfunction

    function automatic int exp_rep(input logic [3:0] op, input bit slow);
        int r;
        case (op)
            4'd0, 4'd1: r = 3;
            4'd2, 4'd3: r = 5;
            4'd4, 4'd5: r = 36;
            4'd6, 4'd7: r = 68;
            4'd8, 4'd9: r = 2;
            default:    r = 3;
        endcase
        if (slow && !(op inside {4'd4, 4'd5, 4'd6, 4'd7})) r++;
        return r;
    endfunction

    function automatic string vtag(input logic [3:0] op, input logic [63:0] b);
        if (op <= 4'd1) return "R2 mul32";
        if (op <= 4'd3) return "R3 mul64";
        if (op <= 4'd5) return (b[31:0] == 0) ? "R5 div32 by zero" : "R4 div32";
        if (op <= 4'd7) return (b == 0) ? "R5 div64 by zero" : "R4 div64";
        return "R6 accumulate";
    endfunction

    function automatic void ref_step(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                                     inout logic [63:0] hi, inout logic [63:0] lo);
        logic [127:0]        xa, xb, prod;
        logic signed [127:0] sa, sb, sq, sr;
        logic [63:0]         acc;
        bit                  sg;
        sg = (op[0] == 1'b0);
        if (op inside {4'd2, 4'd3, 4'd6, 4'd7}) begin
            xa = sg ? {{64{a[63]}}, a} : {64'd0, a};
            xb = sg ? {{64{b[63]}}, b} : {64'd0, b};
        end else begin
            xa = sg ? {{96{a[31]}}, a[31:0]} : {96'd0, a[31:0]};
            xb = sg ? {{96{b[31]}}, b[31:0]} : {96'd0, b[31:0]};
        end
        prod = xa * xb;
        sa = xa;
        sb = xb;
        case (op)
            4'd0, 4'd1: begin
                hi = {{32{prod[63]}}, prod[63:32]};
                lo = {{32{prod[31]}}, prod[31:0]};
            end
            4'd2, 4'd3: begin
                hi = prod[127:64];
                lo = prod[63:0];
            end
            4'd4, 4'd5: begin
                if (b[31:0] == 0) begin
                    lo = '1;
                    hi = {{32{a[31]}}, a[31:0]};
                end else begin
                    sq = sa / sb;
                    sr = sa % sb;
                    lo = {{32{sq[31]}}, sq[31:0]};
                    hi = {{32{sr[31]}}, sr[31:0]};
                end
            end
            4'd6, 4'd7: begin
                if (b == 0) begin
                    lo = '1;
                    hi = a;
                end else begin
                    sq = sa / sb;
                    sr = sa % sb;
                    lo = sq[63:0];
                    hi = sr[63:0];
                end
            end
            default: begin
                acc = {hi[31:0], lo[31:0]};
                acc = (op >= 4'd10) ? (acc - prod[63:0]) : (acc + prod[63:0]);
                hi = {{32{acc[63]}}, acc[63:32]};
                lo = {{32{acc[31]}}, acc[31:0]};
            end
        endcase
    endfunction

    task automatic do_reset(input bit slow);
        rst_n       = 1'b0;
        slow_mul_i  = slow;
        req_valid_i = 1'b0;
        rd_req_i    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        slow_mul_i = ~slow;
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(hi_o == 0 && lo_o == 0, "R1 HI/LO after reset", {hi_o, lo_o}, 0);
        chk(req_stall_o == 1'b0 && rd_stall_o == 1'b0, "R1 stalls after reset",
            {req_stall_o, rd_stall_o}, 0);
        m_hi = '0;
        m_lo = '0;
    endtask

    task automatic run_single(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, input bit slow);
        int          n_busy;
        int          n_rd;
        int          lat;
        logic [63:0] eh, el, oh, ol;
        eh = m_hi;
        el = m_lo;
        ref_step(op, a, b, eh, el);
        lat = exp_lat(op, slow);
        oh = hi_o;
        ol = lo_o;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_op_i    = op;
        req_a_i     = a;
        req_b_i     = b;
        rd_req_i    = 1'b1;
        #1;
        chk(req_stall_o == 1'b0, "R8 no stall when idle", req_stall_o, 0);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(hi_o == oh && lo_o == ol, "R12 HI/LO held before completion", {hi_o, lo_o}, {oh, ol});
        n_busy = 0;
        n_rd   = 0;
        while (busy_o && n_busy < 200) begin
            n_busy++;
            if (rd_stall_o) n_rd++;
            @(negedge clk);
        end
        if (rd_stall_o) n_rd++;
        rd_req_i = 1'b0;
        chk(n_busy == lat - 1, slow ? "R10 stretched latency" : "R7 latency", n_busy, lat - 1);
        chk(n_rd == lat - 1, "R9 read stall cycles", n_rd, lat - 1);
        chk(hi_o == eh && lo_o == el, vtag(op, b), {hi_o, lo_o}, {eh, el});
        m_hi = hi_o;
        m_lo = lo_o;
    endtask

    task automatic run_pair(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                            input logic [63:0] c, input logic [63:0] d, input bit slow);
        int          n_st;
        int          rep;
        logic [63:0] eh, el;
        eh = m_hi;
        el = m_lo;
        ref_step(op, a, b, eh, el);
        ref_step(4'd8, c, d, eh, el);
        rep = exp_rep(op, slow);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_op_i    = op;
        req_a_i     = a;
        req_b_i     = b;
        @(negedge clk);
        req_op_i = 4'd8;
        req_a_i  = c;
        req_b_i  = d;
        #1;
        n_st = 0;
        while (req_stall_o && n_st < 200) begin
            n_st++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid_i = 1'b0;
        while (busy_o) @(negedge clk);
        chk(n_st == rep - 1, slow ? "R10 stretched repeat" : "R8 repeat interval", n_st, rep - 1);
        chk(hi_o == eh && lo_o == el, "R8 chained accumulate", {hi_o, lo_o}, {eh, el});
        m_hi = hi_o;
        m_lo = lo_o;
    endtask

    task automatic run_reserved();
        logic [63:0] oh, ol;
        oh = hi_o;
        ol = lo_o;
        for (int k = 12; k < 16; k++) begin
            @(negedge clk);
            req_valid_i = 1'b1;
            req_op_i    = 4'(k);
            req_a_i     = 64'h55;
            req_b_i     = 64'h3;
            #1;
            chk(req_stall_o == 1'b0, "R11 reserved not stalled", req_stall_o, 0);
            @(negedge clk);
            req_valid_i = 1'b0;
            chk(busy_o == 1'b0, "R11 reserved not busy", busy_o, 0);
            repeat (4) @(negedge clk);
            chk(hi_o == oh && lo_o == ol, "R11 reserved leaves HI/LO", {hi_o, lo_o}, {oh, ol});
        end
    endtask

    task automatic sweep(input bit slow);
        for (int op = 0; op < 12; op++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    run_single(4'(op), vals[i], vals[j], slow);
        for (int op = 0; op < 12; op++)
            run_pair(4'(op), vals[5], vals[1], vals[2], vals[5], slow);
        run_reserved();
    endtask

    initial begin
        vals[0] = 64'h0000_0000_0000_0007;
        vals[1] = 64'hFFFF_FFFF_FFFF_FFFD;
        vals[2] = 64'h8000_0000_8000_0000;
        vals[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[4] = 64'h0000_0000_0000_0000;
        vals[5] = 64'h1234_5678_9ABC_DEF1;
        vals[6] = 64'h8000_0000_0000_0000;
        do_reset(1'b0);
        sweep(1'b0);
        do_reset(1'b1);
        sweep(1'b1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule